// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block decides when a small processor core takes an interrupt. Two sources feed it: a falling edge on an external interrupt pin and a one-clock overflow pulse from a timer. Each source owns a request flag and an enable bit. One global enable bit gates both sources. All of these bits sit in a single 8-bit control register that the core writes through a simple write strobe and reads back at any time.

Requests may arrive on any clock. The block evaluates them only on cycles marked by the instruction-phase strobe, once per instruction cycle. If the global enable is set and the two-level return stack has room, the highest-priority enabled request is taken. The block then emits a one-cycle acknowledge together with the branch vector, clears the serviced flag and drops the global enable so that the handler is not nested. While the stack is full, requests stay recorded and wait. A return-from-interrupt strobe restores the global enable.

While the core is halted, the block also raises a wake-up request when a source becomes pending. A source that was already pending when the halt began is not counted.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. Field positions are: bit 0 global enable, bit 1 external enable, bit 2 timer enable, bit 4 external flag, bit 5 timer flag. Bits 3, 6 and 7 always read 0, so writing 0xFF reads back as 0x37.
- R2: A high-to-low transition of `ext_pin` sets the external flag, which becomes visible on `ctrl_rdata` three clocks after the pin changes. A low-to-high transition sets nothing.
- R3: A one-clock `tmr_ovf` pulse sets the timer flag.
- R4: An acknowledge is issued only at a clock where `phase_tick` is high and `reg_wr` is low, the global enable is set, `stack_full` is low, and at least one source has both its flag and its enable set. `irq_ack` is a one-cycle pulse and `irq_vec` is valid with it. A flagged source whose enable is clear is never acknowledged.
- R5: When both sources qualify, the external source is taken first. Its vector is 0x004. The timer vector is 0x008.
- R6: An acknowledge clears the serviced flag and the global enable. The other flag keeps its value.
- R7: While `stack_full` is high, no acknowledge occurs and flags are kept. Once it falls, the pending request is acknowledged at a later tick.
- R8: A `reti` strobe sets the global enable. Besides a register write, no other input sets it.
- R9: A flag stays set until it is serviced or cleared by a register write with that bit at 0. Writing 1 to a flag bit sets it.
- R10: While `halt` is high, `wake_req` rises one clock after the flag of a source that was clear at halt entry becomes set. A source already flagged at halt entry does not wake. `wake_req` is low when `halt` is low.
- R11: A hardware event arriving in the same clock as a register write that clears its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_tick | input | 1 | One-clock strobe per instruction cycle; acknowledge decisions happen only here |
| ext_pin | input | 1 | External interrupt pin (idle high, asynchronous) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| stack_full | input | 1 | Return stack has no free level |
| reti | input | 1 | Return-from-interrupt strobe |
| halt | input | 1 | Core is in the halted state |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read value |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| irq_vec | output | VEC_W | Branch vector, valid with `irq_ack` |
| wake_req | output | 1 | Wake-up request while halted |

## Verification
The request logic is driven by three kinds of input. Software writes exercise the field positions and the reserved bits. Pin edges in both directions separate true falling-edge detection from level sensing. Timer pulses are sent alone and together with a clearing write, which shows whether a hardware event beats a software clear. Raising both requests with the global enable off and then turning it on tells apart a fixed priority order from arrival order, and the state between the two acknowledges shows whether only the serviced flag is cleared. Keeping the stack full across several ticks and then releasing it distinguishes a held request from a dropped one. Halting with one flag already set and then firing the other source separates the arming captured at halt entry from plain flag sensing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC      = 2;
  localparam int REG_W     = 8;
  localparam int GIE_BIT   = 0;
  localparam int EN_BASE   = 1;
  localparam int FLAG_BASE = 4;

  typedef enum logic [0:0] {
    SRC_EXT = 1'b0,
    SRC_TMR = 1'b1
  } src_e;

  function automatic int vec_of(input src_e s, input int stride);
    return (int'(s) + 1) * stride;
  endfunction
endpackage

// File: rtl/irqc_fall_det.sv
module irqc_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic            any,
  output src_e            sel
);
  always_comb begin
    sel = SRC_EXT;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) sel = src_e'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/irqc_wake.sv
module irqc_wake
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            halt,
  input  logic [NSRC-1:0] flags,
  output logic            wake
);
  logic            halt_q;
  logic [NSRC-1:0] armed_q;
  logic [NSRC-1:0] armed_now;
  logic            wake_q;

  assign armed_now = (halt && !halt_q) ? ~flags : armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b0;
      armed_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      halt_q  <= halt;
      armed_q <= armed_now;
      wake_q  <= halt && |(armed_now & flags);
    end
  end

  assign wake = wake_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int VEC_W       = 10,
  parameter int VEC_STRIDE  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_tick,
  input  logic             ext_pin,
  input  logic             tmr_ovf,
  input  logic             stack_full,
  input  logic             reti,
  input  logic             halt,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] ctrl_rdata,
  output logic             irq_ack,
  output logic [VEC_W-1:0] irq_vec,
  output logic             wake_req
);
  logic             gie_q;
  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  flag_q;
  logic [NSRC-1:0]  set_ev;
  logic [NSRC-1:0]  req;
  logic             ext_fall;
  logic             any_req;
  src_e             pick;
  logic             take;
  logic             ack_q;
  logic [VEC_W-1:0] vec_q;

  irqc_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
    .clk (clk),
    .rst (rst),
    .pin (ext_pin),
    .fall(ext_fall)
  );

  assign set_ev = {tmr_ovf, ext_fall};
  assign req    = flag_q & en_q;

  irqc_arbiter u_arb (
    .req(req),
    .any(any_req),
    .sel(pick)
  );

  assign take = phase_tick && gie_q && !stack_full && !reg_wr && any_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= take;
      if (take) vec_q <= VEC_W'(vec_of(pick, VEC_STRIDE));
      if (take)        gie_q <= 1'b0;
      else if (reg_wr) gie_q <= reg_wdata[GIE_BIT];
      else if (reti)   gie_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]   <= 1'b0;
        flag_q[i] <= 1'b0;
      end else begin
        if (reg_wr) en_q[i] <= reg_wdata[EN_BASE+i];
        if (set_ev[i])                      flag_q[i] <= 1'b1;
        else if (reg_wr)                    flag_q[i] <= reg_wdata[FLAG_BASE+i];
        else if (take && pick == src_e'(i)) flag_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl_rdata          = '0;
    ctrl_rdata[GIE_BIT] = gie_q;
    for (int i = 0; i < NSRC; i++) begin
      ctrl_rdata[EN_BASE+i]   = en_q[i];
      ctrl_rdata[FLAG_BASE+i] = flag_q[i];
    end
  end

  irqc_wake u_wake (
    .clk  (clk),
    .rst  (rst),
    .halt (halt),
    .flags(flag_q),
    .wake (wake_req)
  );

  assign irq_ack = ack_q;
  assign irq_vec = vec_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int VEC_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             phase_tick,
  input logic             stack_full,
  input logic             halt,
  input logic [7:0]       ctrl_rdata,
  input logic             irq_ack,
  input logic [VEC_W-1:0] irq_vec,
  input logic             wake_req
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[3] == 1'b0 && ctrl_rdata[7:6] == 2'b00); // R1
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R4
  AST_ACK_AT_TICK: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(phase_tick)); // R4
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (irq_vec == VEC_W'(4) || irq_vec == VEC_W'(8))); // R5
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_vec == VEC_W'(8)) |-> !($past(ctrl_rdata[4]) && $past(ctrl_rdata[1]))); // R5
  AST_GIE_DROPS: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !ctrl_rdata[0]); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !$past(stack_full)); // R7
  AST_WAKE_HALTED: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(halt)); // R10
endmodule

bind irq_vector_ctrl irqc_checker #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase_tick(phase_tick),
  .stack_full(stack_full),
  .halt      (halt),
  .ctrl_rdata(ctrl_rdata),
  .irq_ack   (irq_ack),
  .irq_vec   (irq_vec),
  .wake_req  (wake_req)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          phase_tick = 1'b0;
  logic          ext_pin = 1'b1;
  logic          tmr_ovf = 1'b0;
  logic          stack_full = 1'b0;
  logic          reti = 1'b0;
  logic          halt = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    ctrl_rdata;
  logic          irq_ack;
  logic [VW-1:0] irq_vec;
  logic          wake_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  int exp_q[$];
  logic [1:0] tick_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tick_cnt   <= tick_cnt + 2'd1;
    phase_tick <= (tick_cnt == 2'd2);
  end

  irq_vector_ctrl #(.VEC_W(VW)) u0 (
    .clk(clk), .rst(rst), .phase_tick(phase_tick), .ext_pin(ext_pin),
    .tmr_ovf(tmr_ovf), .stack_full(stack_full), .reti(reti), .halt(halt),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata),
    .irq_ack(irq_ack), .irq_vec(irq_vec), .wake_req(wake_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && irq_ack) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R4 unexpected ack actual=0x%0h expected=none", irq_vec);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(irq_vec) != e) begin
          n_fails++;
          $display("FAIL R5 vector actual=0x%0h expected=0x%0h", irq_vec, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    check("R1 reset value", ctrl_rdata, 8'h00);
    check("R4 ack idle at reset", irq_ack, 0);
    check("R10 wake idle at reset", wake_req, 0);

    wr(8'hFF);
    // 0xFF sets gie and all enables and flags: two acks expected
    check("R1 reserved bits read zero", ctrl_rdata, 8'h37);
    exp_q.push_back(4); exp_q.push_back(8);
    reti = 1'b0;
    cyc(10);
    // one ack taken, gie dropped
    check("R6 after first ack", ctrl_rdata, 8'h26);
    @(negedge clk); reti = 1'b1; @(negedge clk); reti = 1'b0;
    cyc(10);
    check("R8 reti re-enables, timer serviced", ctrl_rdata, 8'h06);
    check("R5 queue drained", exp_q.size(), 0);

    // R2 falling edge, gie off
    wr(8'h02);
    @(negedge clk); ext_pin = 1'b0;
    cyc(3);
    check("R2 falling edge sets flag", ctrl_rdata, 8'h12);
    cyc(20);
    check("R9 flag persists", ctrl_rdata, 8'h12);
    wr(8'h02);
    check("R9 write zero clears flag", ctrl_rdata, 8'h02);
    @(negedge clk); ext_pin = 1'b1;
    cyc(8);
    check("R2 rising edge ignored", ctrl_rdata, 8'h02);

    // R3 timer pulse, gie off
    wr(8'h04);
    pulse_tmr();
    cyc(2);
    check("R3 timer flag set", ctrl_rdata, 8'h24);

    // R11 hw set beats software clear
    wr(8'h04);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h04; tmr_ovf = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tmr_ovf = 1'b0;
    check("R11 event beats clear", ctrl_rdata, 8'h24);

    // R7 stack full blocks
    wr(8'h00);
    @(negedge clk); stack_full = 1'b1;
    wr(8'h05);
    pulse_tmr();
    cyc(20);
    check("R7 held while full", ctrl_rdata, 8'h25);
    exp_q.push_back(8);
    @(negedge clk); stack_full = 1'b0;
    cyc(10);
    check("R7 serviced after release", ctrl_rdata, 8'h04);
    check("R7 ack delivered", exp_q.size(), 0);

    // R4 disabled source not acked
    wr(8'h01);
    @(negedge clk); ext_pin = 1'b0;
    cyc(20);
    check("R4 disabled source pending", ctrl_rdata, 8'h11);
    @(negedge clk); ext_pin = 1'b1;

    // R10 wake-up
    wr(8'h10);
    @(negedge clk); halt = 1'b1;
    cyc(4);
    check("R10 pre-flagged source no wake", wake_req, 0);
    pulse_tmr();
    cyc(1);
    check("R10 new timer flag wakes", wake_req, 1);
    @(negedge clk); halt = 1'b0;
    cyc(2);
    check("R10 wake low when running", wake_req, 0);

    cyc(4);
    check("R4 no stray acks", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule